// File: doc/BRIEF.md
# Nonvolatile Shadow Memory Controller

This block controls a small byte-wide static memory that has a second, nonvolatile copy behind it. The block runs off a clock and reads four active-low control pins: chip select, output enable, write enable and a nonvolatile select. When the nonvolatile select is high, the pins give ordinary byte reads and writes. When it is low, they request one of two bulk transfers. A save copies the whole working array into the shadow array. A restore copies the shadow array back into the working array. Each transfer starts only when the pins move into the command state. Holding the pins in that state does not start one.

The supply condition arrives as three digital flags. A low-supply flag latches a pending restore, and reset latches one as well. That restore runs by itself once the restore-threshold flag is high. Reads and writes are refused until it has finished. A save is refused while the save-threshold flag is low. The transfer lengths are counts of clock cycles set by parameters. Inside a transfer window the copy moves one byte per clock, driven by an index counter. While a transfer runs, a busy output stays high, the data output stays in high impedance and every pin is ignored.

Top module: `nvsram_ctrl`

## Requirements
- R1: With ce_n and oe_n low, we_n and nv_n high, and no transfer running or pending, dout_en is high after the next rising edge and dout holds the byte stored at addr.
- R2: With ce_n and we_n low and nv_n high, and no transfer running or pending, din is written to the byte at addr on the rising edge.
- R3: In the read state, dout follows each new addr one edge later without any change on the control pins. dout_en goes low one edge after ce_n goes high, oe_n goes high, we_n goes low or nv_n goes low.
- R4: When the pins enter the save state (nv_n, ce_n and we_n low, oe_n high), the controller first sets every shadow byte to 8'hFF and then copies every working byte into the shadow array.
- R5: When the pins enter the restore state (ce_n, oe_n and nv_n low, we_n high), the controller first sets every working byte to zero and then copies the shadow array into it. A restore never changes the shadow array.
- R6: A transfer starts only on the cycle the pins enter its command state. If the pins are still in that state when the transfer ends, no second transfer starts.
- R7: busy rises one edge after the command. It stays high for exactly max(STORE_CYC, 2*2^AW) cycles for a save and max(RECALL_CYC, 2*2^AW) cycles for a restore. While busy is high, dout_en is low and writes on the pins have no effect.
- R8: A save request that arrives while supply_store_ok is low is dropped: busy stays low and the shadow array keeps its contents.
- R9: Reset, or supply_low at any time, latches a pending restore. The pending restore starts once supply_restore_ok is high and supply_low is low, and busy then lasts max(PWRUP_CYC, 2*2^AW) cycles. Reads and writes are refused until it ends.
- R10: With ce_n, oe_n, we_n and nv_n all low, nothing happens: no access, no transfer, and dout_en stays low.
- R11: After reset, busy and dout_en are low.
- R12: If read pins are present when a transfer ends, dout_en goes high one edge after busy falls and shows the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches a pending restore |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable; low means high impedance |
| busy | output | 1 | High for the whole length of any transfer |
| supply_low | input | 1 | Supply below the low threshold |
| supply_store_ok | input | 1 | Supply above the save threshold |
| supply_restore_ok | input | 1 | Supply above the restore threshold |

## Verification
Timing is counted from the rising edge that samples the pins:
- A read or a return to high impedance appears right after that edge.
- A write takes effect at that edge.
- busy rises at the edge after the one that saw the pins enter a command state, and stays high for exactly the configured count.
- Read data returns one edge after busy falls.

The bench changes inputs on falling edges. A driver queues each expected output 1 ns after the rising edge that should produce it, and a monitor compares the queue 2 ns after that edge. Transfer lengths are measured by counting the falling edges on which busy is high. Dropped requests are checked by watching busy for several cycles. The array contents after a transfer are checked by reading every byte back through the read state.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic nv_n;
    } ctl_pins_t;

    typedef enum logic [2:0] {
        PM_IDLE,
        PM_READ,
        PM_WRITE,
        PM_STORE,
        PM_RECALL,
        PM_NOP
    } pin_mode_e;

    typedef enum logic [1:0] {
        XK_NONE,
        XK_STORE,
        XK_RECALL,
        XK_PWRUP
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_COPY,
        PH_SETTLE
    } xfer_phase_e;

    function automatic pin_mode_e decode_pins(input ctl_pins_t p);
        pin_mode_e m;
        m = PM_IDLE;
        if (!p.ce_n) begin
            if (p.nv_n) begin
                if (!p.we_n)      m = PM_WRITE;
                else if (!p.oe_n) m = PM_READ;
            end else begin
                case ({p.oe_n, p.we_n})
                    2'b10:   m = PM_STORE;
                    2'b01:   m = PM_RECALL;
                    2'b00:   m = PM_NOP;
                    default: m = PM_IDLE;
                endcase
            end
        end
        return m;
    endfunction

    function automatic int unsigned at_least(input int unsigned want, input int unsigned floor_v);
        return (want > floor_v) ? want : floor_v;
    endfunction

endpackage

// File: rtl/nvs_decode.sv
module nvs_decode
    import nvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_pins_t pins,
    output pin_mode_e mode,
    output logic      store_edge,
    output logic      recall_edge
);
    logic store_lvl, recall_lvl;
    logic store_q, recall_q;

    always_comb begin
        mode       = decode_pins(pins);
        store_lvl  = (mode == PM_STORE);
        recall_lvl = (mode == PM_RECALL);
    end

    // previous level is tracked every cycle, busy or not, so a held
    // command state never looks like a fresh entry
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            store_q  <= store_lvl;
            recall_q <= recall_lvl;
        end
    end

    assign store_edge  = store_lvl & ~store_q;
    assign recall_edge = recall_lvl & ~recall_q;
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
    import nvs_pkg::*;
#(
    parameter int AW        = 10,
    parameter int STORE_CYC = 2600,
    parameter int RECALL_CYC = 2200,
    parameter int PWRUP_CYC = 3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  xfer_kind_e    start_kind,
    output logic          busy,
    output xfer_kind_e    kind,
    output xfer_phase_e   phase,
    output logic [AW-1:0] idx
);
    localparam int unsigned DEPTH   = 1 << AW;
    localparam int unsigned ST_LEN  = at_least(STORE_CYC, 2 * DEPTH);
    localparam int unsigned RC_LEN  = at_least(RECALL_CYC, 2 * DEPTH);
    localparam int unsigned PU_LEN  = at_least(PWRUP_CYC, 2 * DEPTH);
    localparam int unsigned MAX_LEN = at_least(at_least(ST_LEN, RC_LEN), PU_LEN);
    localparam int          CNT_W   = $clog2(MAX_LEN) + 1;

    logic             busy_q;
    xfer_kind_e       kind_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    function automatic logic [CNT_W-1:0] last_of(input xfer_kind_e k);
        case (k)
            XK_STORE:  return CNT_W'(ST_LEN - 1);
            XK_RECALL: return CNT_W'(RC_LEN - 1);
            default:   return CNT_W'(PU_LEN - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            kind_q <= XK_NONE;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                kind_q <= start_kind;
                cnt_q  <= '0;
                last_q <= last_of(start_kind);
            end
        end else if (cnt_q == last_q) begin
            busy_q <= 1'b0;
            kind_q <= XK_NONE;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (!busy_q)                       phase = PH_IDLE;
        else if (32'(cnt_q) < DEPTH)       phase = PH_ERASE;
        else if (32'(cnt_q) < 2 * DEPTH)   phase = PH_COPY;
        else                               phase = PH_SETTLE;
    end

    assign busy = busy_q;
    assign kind = kind_q;
    assign idx  = cnt_q[AW-1:0];
endmodule

// File: rtl/nvs_bank.sv
module nvs_bank #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
    import nvs_pkg::*;
#(
    parameter int AW         = 10,
    parameter int STORE_CYC  = 2600,
    parameter int RECALL_CYC = 2200,
    parameter int PWRUP_CYC  = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              nv_n,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    input  logic              supply_low,
    input  logic              supply_store_ok,
    input  logic              supply_restore_ok
);
    localparam logic [BYTE_W-1:0] SHADOW_ERASED = '1;
    localparam logic [BYTE_W-1:0] SRAM_CLEARED  = '0;

    ctl_pins_t   pins;
    pin_mode_e   mode;
    logic        store_edge, recall_edge;
    logic        seq_busy;
    xfer_kind_e  seq_kind;
    xfer_phase_e seq_phase;
    logic [AW-1:0] seq_idx;

    logic        pend_q;
    logic        access_ok;
    logic        store_go, recall_go, pwrup_go, xfer_start;
    xfer_kind_e  xfer_kind;

    logic              sram_we, shadow_we;
    logic [AW-1:0]     sram_waddr, sram_raddr;
    logic [BYTE_W-1:0] sram_wdata, sram_rdata, shadow_wdata, shadow_rdata;

    assign pins = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, nv_n: nv_n};

    nvs_decode u_dec (
        .clk         (clk),
        .rst         (rst),
        .pins        (pins),
        .mode        (mode),
        .store_edge  (store_edge),
        .recall_edge (recall_edge)
    );

    // start arbitration
    assign access_ok = ~seq_busy & ~pend_q;
    assign store_go  = store_edge & access_ok & supply_store_ok;
    assign recall_go = recall_edge & access_ok;
    assign pwrup_go  = pend_q & supply_restore_ok & ~supply_low & ~seq_busy;
    assign xfer_start = store_go | recall_go | pwrup_go;

    always_comb begin
        if (pwrup_go)       xfer_kind = XK_PWRUP;
        else if (store_go)  xfer_kind = XK_STORE;
        else if (recall_go) xfer_kind = XK_RECALL;
        else                xfer_kind = XK_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)             pend_q <= 1'b1;
        else if (supply_low) pend_q <= 1'b1;
        else if (pwrup_go)   pend_q <= 1'b0;
    end

    nvs_xfer_seq #(
        .AW         (AW),
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .PWRUP_CYC  (PWRUP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (xfer_start),
        .start_kind (xfer_kind),
        .busy       (seq_busy),
        .kind       (seq_kind),
        .phase      (seq_phase),
        .idx        (seq_idx)
    );

    // working array port steering
    always_comb begin
        sram_we    = 1'b0;
        sram_waddr = addr;
        sram_wdata = din;
        if (seq_busy) begin
            if (seq_kind == XK_RECALL || seq_kind == XK_PWRUP) begin
                case (seq_phase)
                    PH_ERASE: begin
                        sram_we    = 1'b1;
                        sram_waddr = seq_idx;
                        sram_wdata = SRAM_CLEARED;
                    end
                    PH_COPY: begin
                        sram_we    = 1'b1;
                        sram_waddr = seq_idx;
                        sram_wdata = shadow_rdata;
                    end
                    default: sram_we = 1'b0;
                endcase
            end
        end else if (access_ok && mode == PM_WRITE) begin
            sram_we = 1'b1;
        end
    end

    assign sram_raddr   = seq_busy ? seq_idx : addr;
    assign shadow_we    = seq_busy && seq_kind == XK_STORE &&
                          (seq_phase == PH_ERASE || seq_phase == PH_COPY);
    assign shadow_wdata = (seq_phase == PH_COPY) ? sram_rdata : SHADOW_ERASED;

    nvs_bank #(.AW(AW), .DW(BYTE_W)) u_sram (
        .clk   (clk),
        .we    (sram_we),
        .waddr (sram_waddr),
        .wdata (sram_wdata),
        .raddr (sram_raddr),
        .rdata (sram_rdata)
    );

    nvs_bank #(.AW(AW), .DW(BYTE_W)) u_shadow (
        .clk   (clk),
        .we    (shadow_we),
        .waddr (seq_idx),
        .wdata (shadow_wdata),
        .raddr (seq_idx),
        .rdata (shadow_rdata)
    );

    // registered read path
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else if (access_ok && mode == PM_READ) begin
            dout_en <= 1'b1;
            dout    <= sram_rdata;
        end else begin
            dout_en <= 1'b0;
        end
    end

    assign busy = seq_busy;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk
    import nvs_pkg::*;
#(
    parameter int AW         = 10,
    parameter int STORE_CYC  = 2600,
    parameter int RECALL_CYC = 2200,
    parameter int PWRUP_CYC  = 3000
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       dout_en,
    input logic       pend,
    input logic       store_ok,
    input xfer_kind_e kind,
    input logic [3:0] pins
);
    localparam int unsigned DEPTH  = 1 << AW;
    localparam int unsigned ST_LEN = at_least(STORE_CYC, 2 * DEPTH);
    localparam int unsigned RC_LEN = at_least(RECALL_CYC, 2 * DEPTH);
    localparam int unsigned PU_LEN = at_least(PWRUP_CYC, 2 * DEPTH);

    int unsigned run_len;
    xfer_kind_e  kind_seen;

    function automatic int unsigned want_len(input xfer_kind_e k);
        case (k)
            XK_STORE:  return ST_LEN;
            XK_RECALL: return RC_LEN;
            default:   return PU_LEN;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= 0;
            kind_seen <= XK_NONE;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
            if (busy) kind_seen <= kind;
        end
    end

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !dout_en);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == want_len(kind_seen));

    // R8
    store_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && kind == XK_STORE) |-> $past(store_ok));

    // R6
    no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $stable(pins) && !pend) |=> !busy);

    // R9
    pend_block_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && $past(pend)) |-> !dout_en);
endmodule

bind nvsram_ctrl nvs_ctrl_chk #(
    .AW         (AW),
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .PWRUP_CYC  (PWRUP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .dout_en  (dout_en),
    .pend     (pend_q),
    .store_ok (supply_store_ok),
    .kind     (seq_kind),
    .pins     ({ce_n, oe_n, we_n, nv_n})
);

// File: tb/test_nvsram_ctrl.sv
module test_nvsram_ctrl;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;
    localparam int ST_CYC = 40;
    localparam int RC_CYC = 36;
    localparam int PU_CYC = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy;
    logic          supply_low = 1'b0, supply_store_ok = 1'b1, supply_restore_ok = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [7:0] sram_m   [DEPTH];
    logic [7:0] shadow_m [DEPTH];

    typedef struct {
        bit         en;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    nvsram_ctrl #(
        .AW(AW), .STORE_CYC(ST_CYC), .RECALL_CYC(RC_CYC), .PWRUP_CYC(PU_CYC)
    ) i_nvsram_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
        .supply_low(supply_low), .supply_store_ok(supply_store_ok),
        .supply_restore_ok(supply_restore_ok)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_pins(input logic c, input logic o, input logic w, input logic n);
        ce_n = c; oe_n = o; we_n = w; nv_n = n;
    endtask

    // driver side of the scoreboard: expectation for the edge just passed
    task automatic expect_out(input bit en, input logic [7:0] d, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.en = en; e.data = d; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                if (e.en) chk(dout_en && dout == e.data, e.tag, {23'd0, dout_en, dout}, {24'd1, e.data});
                else      chk(!dout_en, e.tag, {31'd0, dout_en}, 32'd0);
            end
        end
    end

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        set_pins(0, 0, 1, 1);
        addr = AW'(a);
        expect_out(1'b1, sram_m[a], tag);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        set_pins(0, 1, 0, 1);
        addr = AW'(a);
        din  = d;
        sram_m[a] = d;
        @(negedge clk);
        set_pins(1, 1, 1, 1);
    endtask

    task automatic idle_pins();
        @(negedge clk);
        set_pins(1, 1, 1, 1);
    endtask

    // called right after command pins were set on a falling edge
    task automatic run_xfer(input int exp_len, input int inject, input string tag);
        int waitc = 0;
        int len   = 0;
        while (!busy && waitc < 5) begin @(negedge clk); waitc++; end
        while (busy && len < 1000) begin
            len++;
            if (inject == 1 && len == 3) begin
                set_pins(0, 1, 0, 1);
                addr = AW'(DEPTH - 1);
                din  = 8'hEE;
            end
            if (inject == 1 && len == 5) set_pins(1, 1, 1, 1);
            if (inject == 2 && len == 3) begin
                set_pins(0, 0, 1, 1);
                addr = AW'(5);
            end
            @(negedge clk);
        end
        chk(len == exp_len, tag, len, exp_len);
    endtask

    task automatic expect_idle(input int n, input string tag);
        repeat (n) begin
            @(negedge clk);
            chk(!busy && !dout_en, tag, {30'd0, busy, dout_en}, 32'd0);
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < DEPTH; i++) rd(i, tag);
        idle_pins();
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog expired act=%0d exp=%0d", 200000, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !dout_en, "R11 reset outputs", {30'd0, busy, dout_en}, 32'd0);

        // R9 read refused while power-up restore pending
        @(negedge clk);
        set_pins(0, 0, 1, 1);
        expect_out(1'b0, 8'h00, "R9 read blocked while pending");
        expect_idle(2, "R9 waits for restore threshold");
        idle_pins();
        supply_restore_ok = 1'b1;
        run_xfer(PU_CYC, 0, "R9 power-up restore length");

        // R2 writes, R1 reads
        for (int i = 0; i < DEPTH; i++) wr(i, 8'(i * 17 + 3));
        read_all("R1 read back after R2 write");

        // R3 address following with pins held
        @(negedge clk);
        set_pins(0, 0, 1, 1);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (i != DEPTH - 1) @(negedge clk);
            addr = AW'(i);
            expect_out(1'b1, sram_m[i], "R3 data follows address");
        end
        @(negedge clk); oe_n = 1'b1;
        expect_out(1'b0, 8'h00, "R3 oe_n high gives high-Z");
        rd(2, "R3 read again");
        @(negedge clk); ce_n = 1'b1;
        expect_out(1'b0, 8'h00, "R3 ce_n high gives high-Z");
        rd(4, "R3 read again");
        @(negedge clk); we_n = 1'b0; din = sram_m[4];
        expect_out(1'b0, 8'h00, "R3 we_n low gives high-Z");
        rd(6, "R3 read again");
        @(negedge clk); set_pins(0, 0, 0, 0);
        expect_out(1'b0, 8'h00, "R10 no-op state high-Z");
        expect_idle(4, "R10 no-op starts nothing");
        idle_pins();

        // R4 save with pins held, R6 no second start
        @(negedge clk); set_pins(0, 1, 0, 0);
        run_xfer(ST_CYC, 0, "R4 save length");
        for (int i = 0; i < DEPTH; i++) shadow_m[i] = sram_m[i];
        expect_idle(8, "R6 held pins do not retrigger");
        idle_pins();

        // R7 write attempt during save is ignored
        for (int i = 0; i < DEPTH; i++) wr(i, 8'hA0 ^ 8'(i));
        @(negedge clk); set_pins(0, 1, 0, 0);
        run_xfer(ST_CYC, 1, "R7 save length with pin activity");
        for (int i = 0; i < DEPTH; i++) shadow_m[i] = sram_m[i];
        idle_pins();
        rd(DEPTH - 1, "R7 write during transfer ignored");
        idle_pins();

        // R5 restore, R12 read on completion
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h5A + 8'(i));
        @(negedge clk); set_pins(0, 0, 1, 0);
        run_xfer(RC_CYC, 2, "R5 restore length");
        for (int i = 0; i < DEPTH; i++) sram_m[i] = shadow_m[i];
        chk(!dout_en, "R12 no drive on the edge busy falls", {31'd0, dout_en}, 32'd0);
        expect_out(1'b1, shadow_m[5], "R12 read one edge after busy falls");
        idle_pins();
        read_all("R5 restored contents");

        // R5 shadow unchanged by restore
        for (int i = 0; i < DEPTH; i++) wr(i, 8'hC3 ^ 8'(i));
        @(negedge clk); set_pins(0, 0, 1, 0);
        run_xfer(RC_CYC, 0, "R5 second restore length");
        for (int i = 0; i < DEPTH; i++) sram_m[i] = shadow_m[i];
        idle_pins();
        read_all("R5 shadow kept across restores");

        // R8 save dropped below threshold
        supply_store_ok = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h33 + 8'(i));
        @(negedge clk); set_pins(0, 1, 0, 0);
        expect_idle(6, "R8 save refused");
        idle_pins();
        supply_store_ok = 1'b1;
        @(negedge clk); set_pins(0, 0, 1, 0);
        run_xfer(RC_CYC, 0, "R8 restore after refused save");
        for (int i = 0; i < DEPTH; i++) sram_m[i] = shadow_m[i];
        idle_pins();
        read_all("R8 shadow unchanged by refused save");

        // R9 low supply latches a restore
        supply_restore_ok = 1'b0;
        @(negedge clk); supply_low = 1'b1;
        repeat (2) @(negedge clk);
        supply_low = 1'b0;
        @(negedge clk);
        set_pins(0, 1, 0, 1); addr = AW'(3); din = 8'h77;
        @(negedge clk);
        set_pins(0, 0, 1, 1);
        expect_out(1'b0, 8'h00, "R9 read blocked after low supply");
        expect_idle(3, "R9 restore waits for threshold");
        idle_pins();
        supply_restore_ok = 1'b1;
        run_xfer(PU_CYC, 0, "R9 automatic restore length");
        read_all("R9 contents after automatic restore");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        report();
        $finish;
    end
endmodule